// File: doc/BRIEF.md
# Load-Store Queue with Store-to-Load Forwarding

This block holds the memory operations of an out-of-order core between dispatch and retirement. Loads and stores enter a circular queue in program order, each tagged with its reorder-buffer slot. The base register value arrives later on a broadcast port and is added to the entry's signed offset to form the effective address. Store data arrives on a separate broadcast port. Address readiness and data readiness are tracked independently per entry.

A load with a known address is held back while any older store has an unknown address. When forwarding is enabled and the youngest older store to the same address holds its data, the load takes that data and makes no memory access. Otherwise the load reads memory through a same-cycle read port. A load that has its data drives it, with its tag, onto the common data bus in a following cycle. Stores write memory only when they sit at the head of the queue and the commit port names their tag. A flush empties the queue.

Top module: `lsq_fwd`

## Requirements
- R1: `q_full` is high when DEPTH entries are held; a dispatch while full is dropped, and a later base broadcast for its tag causes no memory read.
- R2: The effective address is the base value plus the sign-extended OFFW-bit offset, modulo 2^AW; it appears on `mem_rd_addr` in the cycle after the base broadcast for that load.
- R3: A load makes no memory read and no forward while any older store in the queue has an unknown address.
- R4: With `fwd_en`=1, a load whose address equals an older store's takes that store's data once it is known, with `mem_rd_en` low, and waits while the store data is missing.
- R5: When several older stores match a load's address, the youngest of them supplies the forwarded data.
- R6: With `fwd_en`=0, every load reads memory; a load matching an older store waits until that store has retired.
- R7: A load whose data is captured in one cycle drives `cdb_valid`, its tag and the data in the next cycle; one broadcast per cycle, oldest first.
- R8: `mem_wr_en` rises only for a store at the head whose tag equals `commit_tag` with `commit_valid` high, carrying its address and data; a commit with another tag writes nothing and retires nothing.
- R9: `flush` clears every entry: the next cycle shows `q_empty`=1, `q_full`=0, and broadcasts for flushed tags have no effect.
- R10: After reset the queue is empty and not full, and no read, write or bus broadcast is driven.
- R11: A store younger than a load never forwards to it; that load reads memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all entries |
| fwd_en | input | 1 | Enable store-to-load forwarding |
| disp_valid | input | 1 | Dispatch an entry at the tail |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_tag | input | TAGW | Reorder-buffer tag of the entry |
| disp_offset | input | OFFW | Signed address offset |
| q_full | output | 1 | No free entry |
| q_empty | output | 1 | No entry held |
| base_valid | input | 1 | Base register value broadcast |
| base_tag | input | TAGW | Tag of the entry the base belongs to |
| base_value | input | AW | Base register value |
| sdata_valid | input | 1 | Store data broadcast |
| sdata_tag | input | TAGW | Tag of the store |
| sdata_value | input | DW | Store data |
| commit_valid | input | 1 | Reorder buffer commits a tag |
| commit_tag | input | TAGW | Committed tag |
| mem_rd_en | output | 1 | Memory read this cycle |
| mem_rd_addr | output | AW | Read address |
| mem_rd_tag | output | TAGW | Tag of the reading load |
| mem_rd_data | input | DW | Read data, same cycle |
| mem_wr_en | output | 1 | Memory write this cycle |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| cdb_valid | output | 1 | Load result on the data bus |
| cdb_tag | output | TAGW | Tag of the broadcasting load |
| cdb_data | output | DW | Load result |

## Verification
The bench builds the queue with DEPTH=4, AW=16, DW=32, TAGW=4 and OFFW=8. Four entries make the full condition and the dropped fifth dispatch reachable in a handful of cycles, and an 8-bit offset lets negative offsets and address wrap at 16 bits be checked with small values. Three stores ahead of one load fit in the queue, which exposes youngest-match selection, and the same-cycle read port lets the bench model memory as a function of the address so every read result is predictable.

// File: rtl/lsq_fwd_pkg.sv
package lsq_fwd_pkg;

    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } lsq_kind_e;

endpackage

// File: rtl/lsq_fwd_ea.sv
module lsq_fwd_ea #(
    parameter int AW   = 16,
    parameter int OFFW = 8
) (
    input  logic [AW-1:0]   base_i,
    input  logic [OFFW-1:0] off_i,
    output logic [AW-1:0]   ea_o
);
    localparam int EXTW = AW - OFFW;

    logic [AW-1:0] off_ext;

    assign off_ext = {{EXTW{off_i[OFFW-1]}}, off_i};
    assign ea_o    = base_i + off_ext;

endmodule

// File: rtl/lsq_fwd_pick.sv
module lsq_fwd_pick #(
    parameter int N  = 8,
    parameter int PW = 3
) (
    input  logic [N-1:0]  req_i,
    input  logic [PW-1:0] head_i,
    output logic          found_o,
    output logic [PW-1:0] idx_o
);
    always_comb begin
        logic [PW-1:0] p;
        found_o = 1'b0;
        idx_o   = '0;
        p       = '0;
        for (int k = 0; k < N; k++) begin
            p = head_i + PW'(k);
            if (!found_o && req_i[p]) begin
                found_o = 1'b1;
                idx_o   = p;
            end
        end
    end

endmodule

// File: rtl/lsq_fwd.sv
module lsq_fwd
    import lsq_fwd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int TAGW  = 4,
    parameter int OFFW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            fwd_en,
    input  logic            disp_valid,
    input  logic            disp_is_store,
    input  logic [TAGW-1:0] disp_tag,
    input  logic [OFFW-1:0] disp_offset,
    output logic            q_full,
    output logic            q_empty,
    input  logic            base_valid,
    input  logic [TAGW-1:0] base_tag,
    input  logic [AW-1:0]   base_value,
    input  logic            sdata_valid,
    input  logic [TAGW-1:0] sdata_tag,
    input  logic [DW-1:0]   sdata_value,
    input  logic            commit_valid,
    input  logic [TAGW-1:0] commit_tag,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_rd_addr,
    output logic [TAGW-1:0] mem_rd_tag,
    input  logic [DW-1:0]   mem_rd_data,
    output logic            mem_wr_en,
    output logic [AW-1:0]   mem_wr_addr,
    output logic [DW-1:0]   mem_wr_data,
    output logic            cdb_valid,
    output logic [TAGW-1:0] cdb_tag,
    output logic [DW-1:0]   cdb_data
);
    localparam int            PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW:0]   FULL_CNT = (PW+1)'(DEPTH);

    typedef struct packed {
        logic            valid;
        lsq_kind_e       kind;
        logic [TAGW-1:0] tag;
        logic [OFFW-1:0] off;
        logic [AW-1:0]   base;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
        logic            addr_rdy;
        logic            data_rdy;
        logic            cdb_done;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [PW-1:0]    head;
        logic [PW-1:0]    tail;
        logic [PW:0]      cnt;
    } state_t;

    state_t state_q, state_d;

    logic [AW-1:0]    ea       [DEPTH];
    logic [PW-1:0]    age      [DEPTH];
    logic [DW-1:0]    fwd_data [DEPTH];
    logic [DEPTH-1:0] fwd_hit;
    logic [DEPTH-1:0] ld_req;
    logic [DEPTH-1:0] bus_req;
    logic             ld_found, bus_found;
    logic [PW-1:0]    ld_idx, bus_idx;

    // Per-entry effective address from the broadcast base and the entry offset
    for (genvar g = 0; g < DEPTH; g++) begin : g_ea
        lsq_fwd_ea #(.AW(AW), .OFFW(OFFW)) u_ea (
            .base_i (base_value),
            .off_i  (state_q.ent[g].off),
            .ea_o   (ea[g])
        );
        assign age[g] = PW'(g) - state_q.head;
    end

    // Dependence scan: each waiting load against every older store
    always_comb begin
        logic            blocked;
        logic            hit;
        logic            hit_has;
        logic [PW-1:0]   best_age;
        logic [DW-1:0]   hit_val;
        for (int i = 0; i < DEPTH; i++) begin
            blocked  = 1'b0;
            hit      = 1'b0;
            hit_has  = 1'b0;
            best_age = '0;
            hit_val  = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (state_q.ent[j].valid && state_q.ent[j].kind == KIND_STORE
                    && age[j] < age[i]) begin
                    if (!state_q.ent[j].addr_rdy) begin
                        blocked = 1'b1;
                    end else if (state_q.ent[j].addr == state_q.ent[i].addr
                                 && (!hit || age[j] > best_age)) begin
                        hit      = 1'b1;
                        best_age = age[j];
                        hit_has  = state_q.ent[j].data_rdy;
                        hit_val  = state_q.ent[j].data;
                    end
                end
            end
            if (hit && (!fwd_en || !hit_has)) begin
                blocked = 1'b1;
            end
            ld_req[i]   = state_q.ent[i].valid && state_q.ent[i].kind == KIND_LOAD
                          && state_q.ent[i].addr_rdy && !state_q.ent[i].data_rdy
                          && !blocked;
            fwd_hit[i]  = hit;
            fwd_data[i] = hit_val;
            bus_req[i]  = state_q.ent[i].valid && state_q.ent[i].kind == KIND_LOAD
                          && state_q.ent[i].data_rdy && !state_q.ent[i].cdb_done;
        end
    end

    lsq_fwd_pick #(.N(DEPTH), .PW(PW)) u_pick_ld (
        .req_i   (ld_req),
        .head_i  (state_q.head),
        .found_o (ld_found),
        .idx_o   (ld_idx)
    );

    lsq_fwd_pick #(.N(DEPTH), .PW(PW)) u_pick_bus (
        .req_i   (bus_req),
        .head_i  (state_q.head),
        .found_o (bus_found),
        .idx_o   (bus_idx)
    );

    // Next-state computation
    always_comb begin
        ent_t hd;
        logic retire;
        logic accept;
        state_d     = state_q;
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        mem_rd_tag  = '0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = '0;
        mem_wr_data = '0;
        cdb_valid   = 1'b0;
        cdb_tag     = '0;
        cdb_data    = '0;
        retire      = 1'b0;
        hd          = state_q.ent[state_q.head];
        accept      = disp_valid && (state_q.cnt != FULL_CNT);

        // Load issue: forward or read memory
        if (ld_found) begin
            if (fwd_hit[ld_idx]) begin
                state_d.ent[ld_idx].data = fwd_data[ld_idx];
            end else begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = state_q.ent[ld_idx].addr;
                mem_rd_tag  = state_q.ent[ld_idx].tag;
                state_d.ent[ld_idx].data = mem_rd_data;
            end
            state_d.ent[ld_idx].data_rdy = 1'b1;
        end

        // Common data bus: oldest finished load
        if (bus_found) begin
            cdb_valid = 1'b1;
            cdb_tag   = state_q.ent[bus_idx].tag;
            cdb_data  = state_q.ent[bus_idx].data;
            state_d.ent[bus_idx].cdb_done = 1'b1;
        end

        // Operand broadcasts
        for (int i = 0; i < DEPTH; i++) begin
            if (base_valid && state_q.ent[i].valid && !state_q.ent[i].addr_rdy
                && state_q.ent[i].tag == base_tag) begin
                state_d.ent[i].base     = base_value;
                state_d.ent[i].addr     = ea[i];
                state_d.ent[i].addr_rdy = 1'b1;
            end
            if (sdata_valid && state_q.ent[i].valid && state_q.ent[i].kind == KIND_STORE
                && !state_q.ent[i].data_rdy && state_q.ent[i].tag == sdata_tag) begin
                state_d.ent[i].data     = sdata_value;
                state_d.ent[i].data_rdy = 1'b1;
            end
        end

        // Commit at the head
        if (commit_valid && hd.valid && hd.tag == commit_tag) begin
            if (hd.kind == KIND_STORE && hd.addr_rdy && hd.data_rdy) begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = hd.addr;
                mem_wr_data = hd.data;
                retire      = 1'b1;
            end else if (hd.kind == KIND_LOAD && hd.cdb_done) begin
                retire      = 1'b1;
            end
        end
        if (retire) begin
            state_d.ent[state_q.head] = '0;
            state_d.head              = state_q.head + 1'b1;
        end

        // Dispatch at the tail
        if (accept) begin
            state_d.ent[state_q.tail]       = '0;
            state_d.ent[state_q.tail].valid = 1'b1;
            state_d.ent[state_q.tail].kind  = disp_is_store ? KIND_STORE : KIND_LOAD;
            state_d.ent[state_q.tail].tag   = disp_tag;
            state_d.ent[state_q.tail].off   = disp_offset;
            state_d.tail                    = state_q.tail + 1'b1;
        end
        state_d.cnt = state_q.cnt + (PW+1)'(accept) - (PW+1)'(retire);

        if (flush) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_full  = (state_q.cnt == FULL_CNT);
    assign q_empty = (state_q.cnt == '0);

endmodule

// File: rtl/lsq_fwd_chk.sv
module lsq_fwd_chk (
    input logic clk,
    input logic rst_n,
    input logic flush,
    input logic commit_valid,
    input logic q_full,
    input logic q_empty,
    input logic mem_rd_en,
    input logic mem_wr_en,
    input logic cdb_valid
);
    // R1
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !commit_valid && !flush) |=> q_full);

    // R1
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));

    // R7
    read_then_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !flush) |=> cdb_valid);

    // R8
    write_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> commit_valid);

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q_empty && !cdb_valid && !mem_rd_en && !mem_wr_en));

endmodule

bind lsq_fwd lsq_fwd_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .commit_valid (commit_valid),
    .q_full       (q_full),
    .q_empty      (q_empty),
    .mem_rd_en    (mem_rd_en),
    .mem_wr_en    (mem_wr_en),
    .cdb_valid    (cdb_valid)
);

// File: tb/lsq_fwd_tb.sv
`timescale 1ns/1ps
module lsq_fwd_tb;
    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int TAGW  = 4;
    localparam int OFFW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic            fwd_en = 1'b1;
    logic            disp_valid = 1'b0;
    logic            disp_is_store = 1'b0;
    logic [TAGW-1:0] disp_tag = '0;
    logic [OFFW-1:0] disp_offset = '0;
    logic            q_full, q_empty;
    logic            base_valid = 1'b0;
    logic [TAGW-1:0] base_tag = '0;
    logic [AW-1:0]   base_value = '0;
    logic            sdata_valid = 1'b0;
    logic [TAGW-1:0] sdata_tag = '0;
    logic [DW-1:0]   sdata_value = '0;
    logic            commit_valid = 1'b0;
    logic [TAGW-1:0] commit_tag = '0;
    logic            mem_rd_en;
    logic [AW-1:0]   mem_rd_addr;
    logic [TAGW-1:0] mem_rd_tag;
    logic [DW-1:0]   mem_rd_data;
    logic            mem_wr_en;
    logic [AW-1:0]   mem_wr_addr;
    logic [DW-1:0]   mem_wr_data;
    logic            cdb_valid;
    logic [TAGW-1:0] cdb_tag;
    logic [DW-1:0]   cdb_data;

    int checks = 0;
    int failures = 0;
    logic            wr_seen;
    logic [AW-1:0]   wr_addr_seen;
    logic [DW-1:0]   wr_data_seen;

    always #10 clk = ~clk;

    // Memory model: read data is a function of the address
    assign mem_rd_data = {mem_rd_addr, ~mem_rd_addr};

    lsq_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW), .OFFW(OFFW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fwd_en(fwd_en),
        .disp_valid(disp_valid), .disp_is_store(disp_is_store),
        .disp_tag(disp_tag), .disp_offset(disp_offset),
        .q_full(q_full), .q_empty(q_empty),
        .base_valid(base_valid), .base_tag(base_tag), .base_value(base_value),
        .sdata_valid(sdata_valid), .sdata_tag(sdata_tag), .sdata_value(sdata_value),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_tag(mem_rd_tag),
        .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
    );

    // {base, offset, expected address}
    localparam logic [39:0] EA_VEC [4] = '{
        {16'h0100, 8'h10, 16'h0110},
        {16'h0100, 8'hF0, 16'h00F0},
        {16'hFFF8, 8'h10, 16'h0008},
        {16'h1234, 8'h80, 16'h11B4}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic disp(input logic st, input logic [TAGW-1:0] t, input logic [OFFW-1:0] off);
        disp_valid = 1'b1; disp_is_store = st; disp_tag = t; disp_offset = off;
        @(posedge clk); #1;
        disp_valid = 1'b0; #1;
    endtask

    task automatic base(input logic [TAGW-1:0] t, input logic [AW-1:0] v);
        base_valid = 1'b1; base_tag = t; base_value = v;
        @(posedge clk); #1;
        base_valid = 1'b0; #1;
    endtask

    task automatic sdata(input logic [TAGW-1:0] t, input logic [DW-1:0] v);
        sdata_valid = 1'b1; sdata_tag = t; sdata_value = v;
        @(posedge clk); #1;
        sdata_valid = 1'b0; #1;
    endtask

    task automatic commit(input logic [TAGW-1:0] t);
        commit_valid = 1'b1; commit_tag = t; #1;
        wr_seen = mem_wr_en; wr_addr_seen = mem_wr_addr; wr_data_seen = mem_wr_data;
        @(posedge clk); #1;
        commit_valid = 1'b0; #1;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1; #1;

        // R10 reset state
        chk("R10 empty", q_empty, 1);
        chk("R10 full", q_full, 0);
        chk("R10 rd", mem_rd_en, 0);
        chk("R10 wr", mem_wr_en, 0);
        chk("R10 cdb", cdb_valid, 0);

        // R2 / R7 vector walk
        for (int v = 0; v < 4; v++) begin
            logic [AW-1:0] b, e;
            logic [OFFW-1:0] o;
            logic [TAGW-1:0] t;
            b = EA_VEC[v][39:24]; o = EA_VEC[v][23:16]; e = EA_VEC[v][15:0];
            t = TAGW'(v + 1);
            disp(1'b0, t, o);
            base(t, b);
            chk("R2 rd_en", mem_rd_en, 1);
            chk("R2 addr", mem_rd_addr, e);
            chk("R7 rd_tag", mem_rd_tag, t);
            chk("R7 no bus yet", cdb_valid, 0);
            cyc();
            chk("R7 bus valid", cdb_valid, 1);
            chk("R7 bus tag", cdb_tag, t);
            chk("R7 bus data", cdb_data, {e, ~e});
            cyc();
            chk("R7 single bus", cdb_valid, 0);
            commit(t);
            chk("R7 retired", q_empty, 1);
        end

        // R3 older store with unknown address blocks load
        disp(1'b1, 4'd2, 8'h00);
        disp(1'b0, 4'd3, 8'h00);
        base(4'd3, 16'h0300);
        chk("R3 blocked rd", mem_rd_en, 0);
        cyc();
        chk("R3 still blocked", mem_rd_en, 0);
        chk("R3 no bus", cdb_valid, 0);
        base(4'd2, 16'h0400);
        chk("R3 released rd", mem_rd_en, 1);
        chk("R3 released addr", mem_rd_addr, 16'h0300);
        cyc();
        chk("R3 bus tag", cdb_tag, 4'd3);
        cyc();
        sdata(4'd2, 32'hCAFE0001);
        commit(4'd5);
        chk("R8 wrong tag no write", wr_seen, 0);
        chk("R8 wrong tag no retire", q_empty, 0);
        commit(4'd2);
        chk("R8 write en", wr_seen, 1);
        chk("R8 write addr", wr_addr_seen, 16'h0400);
        chk("R8 write data", wr_data_seen, 32'hCAFE0001);
        commit(4'd3);
        chk("R8 drained", q_empty, 1);

        // R4 forwarding, waiting for store data
        disp(1'b1, 4'd4, 8'h00);
        disp(1'b0, 4'd5, 8'h04);
        base(4'd4, 16'h0504);
        base(4'd5, 16'h0500);
        chk("R4 wait no rd", mem_rd_en, 0);
        cyc();
        chk("R4 wait no bus", cdb_valid, 0);
        sdata(4'd4, 32'hDEADBEEF);
        chk("R4 fwd no rd", mem_rd_en, 0);
        cyc();
        chk("R4 bus valid", cdb_valid, 1);
        chk("R4 bus tag", cdb_tag, 4'd5);
        chk("R4 bus data", cdb_data, 32'hDEADBEEF);
        cyc();
        commit(4'd4);
        commit(4'd5);
        chk("R4 drained", q_empty, 1);

        // R5 youngest matching store wins
        disp(1'b1, 4'd1, 8'h00);
        disp(1'b1, 4'd2, 8'h00);
        disp(1'b0, 4'd3, 8'h00);
        base(4'd1, 16'h0600);
        base(4'd2, 16'h0600);
        sdata(4'd1, 32'h00000111);
        sdata(4'd2, 32'h00000222);
        base(4'd3, 16'h0600);
        chk("R5 no rd", mem_rd_en, 0);
        cyc();
        chk("R5 bus data", cdb_data, 32'h00000222);
        cyc();
        commit(4'd1);
        commit(4'd2);
        commit(4'd3);
        chk("R5 drained", q_empty, 1);

        // R11 younger store does not forward
        disp(1'b0, 4'd1, 8'h00);
        disp(1'b1, 4'd2, 8'h00);
        base(4'd2, 16'h0700);
        sdata(4'd2, 32'h00000077);
        base(4'd1, 16'h0700);
        chk("R11 rd", mem_rd_en, 1);
        chk("R11 addr", mem_rd_addr, 16'h0700);
        cyc();
        chk("R11 bus data", cdb_data, 32'h0700F8FF);
        cyc();
        commit(4'd1);
        commit(4'd2);
        chk("R11 drained", q_empty, 1);

        // R6 forwarding disabled
        fwd_en = 1'b0;
        disp(1'b1, 4'd1, 8'h00);
        disp(1'b0, 4'd2, 8'h00);
        base(4'd1, 16'h0800);
        sdata(4'd1, 32'h00000088);
        base(4'd2, 16'h0800);
        chk("R6 wait rd", mem_rd_en, 0);
        cyc();
        chk("R6 wait bus", cdb_valid, 0);
        commit(4'd1);
        chk("R6 rd after retire", mem_rd_en, 1);
        chk("R6 addr", mem_rd_addr, 16'h0800);
        cyc();
        chk("R6 bus data", cdb_data, 32'h0800F7FF);
        cyc();
        commit(4'd2);
        chk("R6 drained", q_empty, 1);
        fwd_en = 1'b1; #1;

        // R1 full and dropped dispatch
        for (int k = 1; k <= DEPTH; k++) disp(1'b0, TAGW'(k), 8'h00);
        chk("R1 full", q_full, 1);
        disp(1'b0, 4'd9, 8'h00);
        base(4'd9, 16'h0900);
        chk("R1 dropped no rd", mem_rd_en, 0);
        chk("R1 still full", q_full, 1);

        // R9 flush
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0; #1;
        chk("R9 empty", q_empty, 1);
        chk("R9 not full", q_full, 0);
        base(4'd1, 16'h0100);
        chk("R9 flushed no rd", mem_rd_en, 0);
        cyc();
        chk("R9 flushed no bus", cdb_valid, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule